// File: doc/BRIEF.md
# Serial Flash Slave Command Front-End

This block is the slave-side serial port of a NOR-style flash device. It watches chip select, the serial clock and up to four data lines. It assembles the opcode, a 24-bit address, a dummy byte and write data into bytes. During a read it shifts data bytes back to the host. The block runs from a single system clock that oversamples the serial pins. It finds serial-clock edges by comparing each sample with the one before, so the serial clock may idle low or idle high (SPI modes 0 and 3).

After reset the port carries one bit per clock. Input arrives on lane 0 and output leaves on lane 1. Opcode 0x38 switches every later command to four bits per clock on all lanes, and opcode 0xFF switches back. In single-bit mode a hold input pauses the transfer and a write-protect input is reported downstream. Both pins are honoured only when the configuration input leaves them enabled.

Towards the register and array controller, the block presents decoded strobes, the assembled address, a write-byte stream limited to one page, and a read-byte request. It also issues commit pulses for program and erase when chip select rises at a valid point.

Top module: `spi_flash_front`

## Requirements
- R1: After reset the block is in single-bit mode, all output enables are 0, and no strobe is active.
- R2: In single-bit mode each byte is sampled MSB first from lane 0 on rising serial-clock edges. A completed opcode pulses op_valid and appears on op_code. Opcode 0x06 pulses wren_stb and opcode 0x04 pulses wrdi_stb.
- R3: Opcode 0x38 sets quad_mode and opcode 0xFF clears it. Each holds in either mode. In quad mode a byte takes two clocks, with the high nibble first on lanes 3..0.
- R4: Opcodes 0x03, 0x0B, 0x02 and 0x20 are followed by a 3-byte address, most significant byte first. The address is presented on addr, with one addr_valid pulse after the third byte.
- R5: Opcodes 0x05 and 0x35 start read data straight after the opcode, and 0x03 starts it after the address. A byte of rd_data is loaded, and rd_next pulses, on the first falling serial-clock edge of each output byte. Bits change on falling edges, MSB first, on lane 1 in single-bit mode or as nibbles on lanes 3..0 in quad mode.
- R6: Opcode 0x0B inserts one dummy byte between the address and the read data, and no rd_next pulse occurs during it.
- R7: After opcode 0x02 and its address, each data byte pulses wr_valid with wr_data, up to 256 bytes; further bytes are dropped. prog_go pulses once when chip select rises after at least one data byte.
- R8: erase_go pulses once when chip select rises after opcode 0x20 and its complete address.
- R9: A chip-select rise in the middle of a byte or an address discards the partial input and issues no commit pulse. The next select starts again at the opcode.
- R10: The output enables are 0010 in single-bit mode and 1111 in quad mode while the read phase is active with chip select low and no hold. Otherwise they are 0000.
- R11: With quad_mode 0 and cfg_pin_dis 0, hold_n low while selected freezes input and output shifting. In quad mode, or with cfg_pin_dis 1, hold_n has no effect.
- R12: wp_active is 1 exactly when quad_mode is 0, cfg_pin_dis is 0 and wp_n is 0.
- R13: Commands behave the same whether the serial clock idles low (mode 0) or high (mode 3) while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| hold_n | input | 1 | Hold request, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| cfg_pin_dis | input | 1 | 1 disables the hold and write-protect pins |
| sio_i | input | 4 | Serial data lanes from the host |
| rd_data | input | 8 | Next read byte from the downstream controller |
| sio_o | output | 4 | Serial data lanes to the host |
| sio_oe | output | 4 | Output enable per lane |
| quad_mode | output | 1 | 1 when four lanes are in use |
| op_valid | output | 1 | Pulse when an opcode completes |
| op_code | output | 8 | Most recent opcode |
| wren_stb | output | 1 | Write-enable command pulse |
| wrdi_stb | output | 1 | Write-disable command pulse |
| addr | output | 24 | Assembled address |
| addr_valid | output | 1 | Pulse when the address is complete |
| wr_valid | output | 1 | Pulse per accepted program data byte |
| wr_data | output | 8 | Program data byte |
| rd_next | output | 1 | Pulse when a read byte is consumed |
| prog_go | output | 1 | Program commit pulse at select rise |
| erase_go | output | 1 | Erase commit pulse at select rise |
| wp_active | output | 1 | Write protection asserted by the pin |

## Verification
A falling serial-clock edge can fall in the same system cycle as an active hold. Hold must win, so the read shifter must neither advance nor request a new byte. The bench provokes this by reading one status byte, asserting hold and then toggling the serial clock several times. It checks that the output enables drop and that rd_next has not pulsed again. After hold is released, the next byte must come out whole. The same clash on the input side is judged by splitting an opcode around a hold period filled with junk clocks, and checking that the decoded opcode is still correct.

// File: rtl/spi_flash_front_pkg.sv
// Shared types and opcode values for the serial flash front-end.
package spi_flash_front_pkg;
    typedef enum logic [2:0] {
        PH_OP, PH_ADDR, PH_DUMMY, PH_WDATA, PH_READ, PH_SKIP
    } phase_t;

    localparam logic [7:0] OP_WREN     = 8'h06;
    localparam logic [7:0] OP_WRDI     = 8'h04;
    localparam logic [7:0] OP_QUAD_ON  = 8'h38;
    localparam logic [7:0] OP_QUAD_OFF = 8'hFF;
    localparam logic [7:0] OP_RD_STAT  = 8'h05;
    localparam logic [7:0] OP_RD_CFG   = 8'h35;
    localparam logic [7:0] OP_READ     = 8'h03;
    localparam logic [7:0] OP_FREAD    = 8'h0B;
    localparam logic [7:0] OP_PROG     = 8'h02;
    localparam logic [7:0] OP_ERASE    = 8'h20;
endpackage

// File: rtl/spi_flash_front_rx.sv
// Input deserializer: gathers one or four bits per enabled shift into a byte.
// Assumes BYTE_W is a multiple of 4 and that the lane width changes only
// between bytes. A clear returns the bit count to zero.
module spi_flash_front_rx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              quad,
    input  logic [3:0]        din,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    logic [BYTE_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_nx;

    // Next shift value and completion flag for the current edge.
    always_comb begin
        byte_val  = quad ? {sh_q[BYTE_W-5:0], din} : {sh_q[BYTE_W-2:0], din[0]};
        cnt_nx    = cnt_q + (quad ? CNT_W'(4) : CNT_W'(1));
        byte_done = shift_en && (cnt_nx == CNT_W'(BYTE_W));
    end

    // Shift register and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (shift_en) begin
            sh_q  <= byte_val;
            cnt_q <= byte_done ? '0 : cnt_nx;
        end
    end
endmodule

// File: rtl/spi_flash_front_tx.sv
// Output serializer: loads a byte on the first shift of each output byte and
// sends it MSB first, as one bit on lane 1 or as nibbles on lanes 3..0.
module spi_flash_front_tx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              quad,
    input  logic [BYTE_W-1:0] load_val,
    output logic [3:0]        dout,
    output logic              load_stb
);
    localparam int TC_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sh_q;
    logic [TC_W-1:0]   cnt_q;
    logic [TC_W-1:0]   last_step;

    // Final step index of a byte for the current lane width.
    always_comb last_step = quad ? TC_W'(BYTE_W/4 - 1) : TC_W'(BYTE_W - 1);

    // Load or shift on each enabled falling edge.
    always_ff @(posedge clk) begin
        load_stb <= 1'b0;
        if (!rst_n || clr) begin
            sh_q  <= '0;
            cnt_q <= '0;
            dout  <= '0;
        end else if (shift_en) begin
            if (cnt_q == '0) begin
                load_stb <= 1'b1;
                dout     <= quad ? load_val[BYTE_W-1 -: 4] : {2'b00, load_val[BYTE_W-1], 1'b0};
                sh_q     <= quad ? (load_val << 4) : (load_val << 1);
            end else begin
                dout     <= quad ? sh_q[BYTE_W-1 -: 4] : {2'b00, sh_q[BYTE_W-1], 1'b0};
                sh_q     <= quad ? (sh_q << 4) : (sh_q << 1);
            end
            cnt_q <= (cnt_q == last_step) ? '0 : cnt_q + TC_W'(1);
        end
    end
endmodule

// File: rtl/spi_flash_front_seq.sv
// Command sequencer: decodes opcodes, steps through the address, dummy, write
// and read phases, caps write data at one page and issues commit pulses when
// chip select rises. Any select rise returns it to the opcode phase.
module spi_flash_front_seq
    import spi_flash_front_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int PAGE_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              cs_rise,
    input  logic              byte_done,
    input  logic [7:0]        byte_val,
    output phase_t            phase,
    output logic              quad_mode,
    output logic              op_valid,
    output logic [7:0]        op_code,
    output logic              wren_stb,
    output logic              wrdi_stb,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_valid,
    output logic              wr_valid,
    output logic [7:0]        wr_data,
    output logic              prog_go,
    output logic              erase_go
);
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int AB_W       = $clog2(ADDR_BYTES + 1);
    localparam int PG_W       = $clog2(PAGE_BYTES + 1);

    logic [AB_W-1:0] abyte_q;
    logic [PG_W-1:0] pg_cnt_q;
    logic            erase_arm_q;

    // Phase machine, decode and strobes.
    always_ff @(posedge clk) begin
        op_valid   <= 1'b0;
        wren_stb   <= 1'b0;
        wrdi_stb   <= 1'b0;
        addr_valid <= 1'b0;
        wr_valid   <= 1'b0;
        prog_go    <= 1'b0;
        erase_go   <= 1'b0;
        if (!rst_n) begin
            phase       <= PH_OP;
            quad_mode   <= 1'b0;
            op_code     <= '0;
            addr        <= '0;
            wr_data     <= '0;
            abyte_q     <= '0;
            pg_cnt_q    <= '0;
            erase_arm_q <= 1'b0;
        end else if (cs_n) begin
            if (cs_rise) begin
                prog_go  <= (pg_cnt_q != '0);
                erase_go <= erase_arm_q;
            end
            phase       <= PH_OP;
            abyte_q     <= '0;
            pg_cnt_q    <= '0;
            erase_arm_q <= 1'b0;
        end else if (byte_done) begin
            case (phase)
                PH_OP: begin
                    op_valid <= 1'b1;
                    op_code  <= byte_val;
                    phase    <= PH_SKIP;
                    case (byte_val)
                        OP_WREN:     wren_stb  <= 1'b1;
                        OP_WRDI:     wrdi_stb  <= 1'b1;
                        OP_QUAD_ON:  quad_mode <= 1'b1;
                        OP_QUAD_OFF: quad_mode <= 1'b0;
                        OP_RD_STAT, OP_RD_CFG: phase <= PH_READ;
                        OP_READ, OP_FREAD, OP_PROG, OP_ERASE: phase <= PH_ADDR;
                        default: ;
                    endcase
                end
                PH_ADDR: begin
                    addr <= {addr[ADDR_W-9:0], byte_val};
                    if (abyte_q == AB_W'(ADDR_BYTES - 1)) begin
                        addr_valid <= 1'b1;
                        case (op_code)
                            OP_READ:  phase <= PH_READ;
                            OP_FREAD: phase <= PH_DUMMY;
                            OP_PROG:  phase <= PH_WDATA;
                            default: begin
                                erase_arm_q <= 1'b1;
                                phase       <= PH_SKIP;
                            end
                        endcase
                    end else begin
                        abyte_q <= abyte_q + AB_W'(1);
                    end
                end
                PH_DUMMY: phase <= PH_READ;
                PH_WDATA: begin
                    if (pg_cnt_q < PG_W'(PAGE_BYTES)) begin
                        wr_valid <= 1'b1;
                        wr_data  <= byte_val;
                        pg_cnt_q <= pg_cnt_q + PG_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/spi_flash_front.sv
// Top of the serial flash slave front-end. Oversamples the serial pins with
// clk (pins assumed synchronous to clk), finds serial-clock edges, applies
// hold gating and drives the data lanes. Inputs shift on rising edges and
// outputs change on falling edges.
module spi_flash_front
    import spi_flash_front_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int PAGE_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              hold_n,
    input  logic              wp_n,
    input  logic              cfg_pin_dis,
    input  logic [3:0]        sio_i,
    input  logic [7:0]        rd_data,
    output logic [3:0]        sio_o,
    output logic [3:0]        sio_oe,
    output logic              quad_mode,
    output logic              op_valid,
    output logic [7:0]        op_code,
    output logic              wren_stb,
    output logic              wrdi_stb,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_valid,
    output logic              wr_valid,
    output logic [7:0]        wr_data,
    output logic              rd_next,
    output logic              prog_go,
    output logic              erase_go,
    output logic              wp_active
);
    localparam int BYTE_W = 8;

    logic   sck_q, cs_q;
    logic   sck_rise, sck_fall, cs_rise, hold_act;
    logic   byte_done;
    logic [BYTE_W-1:0] byte_val;
    phase_t phase;

    // Previous samples of the serial clock and chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    // Edge detection and pin gating.
    always_comb begin
        sck_rise  = sck & ~sck_q;
        sck_fall  = ~sck & sck_q;
        cs_rise   = cs_n & ~cs_q;
        hold_act  = ~quad_mode & ~cfg_pin_dis & ~hold_n & ~cs_n;
        wp_active = ~quad_mode & ~cfg_pin_dis & ~wp_n;
    end

    spi_flash_front_rx #(.BYTE_W(BYTE_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cs_n),
        .shift_en  (sck_rise & ~cs_n & ~hold_act),
        .quad      (quad_mode),
        .din       (sio_i),
        .byte_done (byte_done),
        .byte_val  (byte_val)
    );

    spi_flash_front_tx #(.BYTE_W(BYTE_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cs_n),
        .shift_en (sck_fall & ~cs_n & ~hold_act & (phase == PH_READ)),
        .quad     (quad_mode),
        .load_val (rd_data),
        .dout     (sio_o),
        .load_stb (rd_next)
    );

    spi_flash_front_seq #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .cs_rise    (cs_rise),
        .byte_done  (byte_done),
        .byte_val   (byte_val),
        .phase      (phase),
        .quad_mode  (quad_mode),
        .op_valid   (op_valid),
        .op_code    (op_code),
        .wren_stb   (wren_stb),
        .wrdi_stb   (wrdi_stb),
        .addr       (addr),
        .addr_valid (addr_valid),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .prog_go    (prog_go),
        .erase_go   (erase_go)
    );

    // Registered lane enables for the read phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sio_oe <= 4'b0000;
        else if (!cs_n && !hold_act && phase == PH_READ)
            sio_oe <= quad_mode ? 4'b1111 : 4'b0010;
        else
            sio_oe <= 4'b0000;
    end
endmodule

// File: rtl/spi_flash_front_chk.sv
// Protocol checker for the serial flash front-end, bound to the top module.
module spi_flash_front_chk #(
    parameter int PAGE_BYTES = 256
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       quad_mode,
    input logic [3:0] sio_oe,
    input logic       wp_active,
    input logic       op_valid,
    input logic       wren_stb,
    input logic       wrdi_stb,
    input logic       wr_valid,
    input logic       prog_go,
    input logic       erase_go
);
    localparam int WC_W = $clog2(PAGE_BYTES + 2);
    logic [WC_W-1:0] wr_seen_q;

    // Counts write bytes within the current select.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n)
            wr_seen_q <= '0;
        else if (wr_valid && wr_seen_q <= WC_W'(PAGE_BYTES))
            wr_seen_q <= wr_seen_q + WC_W'(1);
    end

    AST_OE_OFF_DESEL: assert property (@(posedge clk) disable iff (!rst_n) cs_n |=> sio_oe == 4'b0000); // R10
    AST_OE_LANES: assert property (@(posedge clk) disable iff (!rst_n) (sio_oe != 4'b0000) |-> (sio_oe == (quad_mode ? 4'b1111 : 4'b0010))); // R10
    AST_WP_QUAD_OFF: assert property (@(posedge clk) disable iff (!rst_n) quad_mode |-> !wp_active); // R12
    AST_MODE_BY_OPCODE: assert property (@(posedge clk) disable iff (!rst_n) (quad_mode != $past(quad_mode)) |-> op_valid); // R3
    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({wren_stb, wrdi_stb, prog_go, erase_go})); // R2
    AST_PROG_AT_DESEL: assert property (@(posedge clk) disable iff (!rst_n) prog_go |-> $past(cs_n)); // R7
    AST_ERASE_AT_DESEL: assert property (@(posedge clk) disable iff (!rst_n) erase_go |-> $past(cs_n)); // R8
    AST_PAGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) wr_valid |-> wr_seen_q < WC_W'(PAGE_BYTES)); // R7
endmodule

bind spi_flash_front spi_flash_front_chk #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .quad_mode (quad_mode),
    .sio_oe    (sio_oe),
    .wp_active (wp_active),
    .op_valid  (op_valid),
    .wren_stb  (wren_stb),
    .wrdi_stb  (wrdi_stb),
    .wr_valid  (wr_valid),
    .prog_go   (prog_go),
    .erase_go  (erase_go)
);

// File: tb/spi_flash_front_tb.sv
module spi_flash_front_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1, wp_n = 1'b1, cfg_pin_dis = 1'b0;
    logic [3:0] sio_i = 4'h0;
    logic [7:0] rd_data = 8'h00;
    logic [3:0] sio_o, sio_oe;
    logic quad_mode, op_valid, wren_stb, wrdi_stb, addr_valid, wr_valid;
    logic rd_next, prog_go, erase_go, wp_active;
    logic [7:0] op_code, wr_data;
    logic [23:0] addr;

    int checks = 0, fails = 0;
    int n_op = 0, n_wren = 0, n_wrdi = 0, n_av = 0, n_wr = 0, n_rdn = 0, n_prog = 0, n_erase = 0;
    logic [7:0] last_wr = 8'h00;
    bit bq = 1'b0;
    bit idle_hi = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_flash_front u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n), .wp_n(wp_n),
        .cfg_pin_dis(cfg_pin_dis), .sio_i(sio_i), .rd_data(rd_data), .sio_o(sio_o),
        .sio_oe(sio_oe), .quad_mode(quad_mode), .op_valid(op_valid), .op_code(op_code),
        .wren_stb(wren_stb), .wrdi_stb(wrdi_stb), .addr(addr), .addr_valid(addr_valid),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_next(rd_next), .prog_go(prog_go),
        .erase_go(erase_go), .wp_active(wp_active)
    );

    // Pulse counters observed at the ports.
    always @(posedge clk) begin
        if (rst_n) begin
            if (op_valid)   n_op++;
            if (wren_stb)   n_wren++;
            if (wrdi_stb)   n_wrdi++;
            if (addr_valid) n_av++;
            if (wr_valid) begin n_wr++; last_wr = wr_data; end
            if (rd_next)    n_rdn++;
            if (prog_go)    n_prog++;
            if (erase_go)   n_erase++;
        end
    end

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cyc(input logic [3:0] d, output logic [3:0] q);
        sio_i = d;
        sck = 1'b0;
        wait_n(2);
        q = sio_o;
        sck = 1'b1;
        wait_n(2);
    endtask

    task automatic cs_begin();
        sck = idle_hi;
        wait_n(2);
        cs_n = 1'b0;
        wait_n(2);
    endtask

    task automatic cs_end();
        cs_n = 1'b1;
        wait_n(2);
        sck = idle_hi;
        wait_n(3);
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic [3:0] q;
        if (bq) begin
            cyc(b[7:4], q);
            cyc(b[3:0], q);
        end else begin
            for (int i = 7; i >= 0; i--) cyc({3'b000, b[i]}, q);
        end
    endtask

    task automatic recv_byte(output logic [7:0] b);
        logic [3:0] q;
        b = 8'h00;
        if (bq) begin
            cyc(4'h0, q); b[7:4] = q;
            cyc(4'h0, q); b[3:0] = q;
        end else begin
            for (int i = 7; i >= 0; i--) begin cyc(4'h0, q); b[i] = q[1]; end
        end
    endtask

    task automatic one_cmd(input logic [7:0] b);
        cs_begin(); send_byte(b); cs_end();
    endtask

    // {opcode, expected quad_mode after, wren step, wrdi step}
    localparam logic [10:0] VEC [9] = '{
        {8'h06, 1'b0, 1'b1, 1'b0},
        {8'h04, 1'b0, 1'b0, 1'b1},
        {8'hFF, 1'b0, 1'b0, 1'b0},
        {8'h38, 1'b1, 1'b0, 1'b0},
        {8'h06, 1'b1, 1'b1, 1'b0},
        {8'h38, 1'b1, 1'b0, 1'b0},
        {8'h04, 1'b1, 1'b0, 1'b1},
        {8'hFF, 1'b0, 1'b0, 1'b0},
        {8'h06, 1'b0, 1'b1, 1'b0}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [7:0] b;
        int s0, s1, s2;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(2);
        // R1 reset state
        check_eq("R1 quad_mode", quad_mode, 0);
        check_eq("R1 sio_oe", sio_oe, 0);
        check_eq("R1 strobes", {op_valid, wren_stb, wrdi_stb, prog_go, erase_go}, 0);

        // R2 R3 table of single-opcode commands in both widths
        for (int i = 0; i < 9; i++) begin
            logic [10:0] v;
            v = VEC[i];
            s0 = n_op; s1 = n_wren; s2 = n_wrdi;
            one_cmd(v[10:3]);
            check_eq("R2 op_valid", n_op - s0, 1);
            check_eq("R2 op_code", op_code, v[10:3]);
            check_eq("R3 quad_mode", quad_mode, v[2]);
            check_eq("R2 wren", n_wren - s1, v[1]);
            check_eq("R2 wrdi", n_wrdi - s2, v[0]);
            bq = v[2];
        end

        // R5 R10 status read in single mode, two bytes
        rd_data = 8'hA5; s0 = n_rdn;
        cs_begin(); send_byte(8'h05);
        recv_byte(b); check_eq("R5 status byte0", b, 8'hA5);
        check_eq("R10 oe single", sio_oe, 4'b0010);
        recv_byte(b); check_eq("R5 status byte1", b, 8'hA5);
        check_eq("R5 rd_next", n_rdn - s0, 2);
        cs_end();
        check_eq("R10 oe off", sio_oe, 0);

        // R11 hold during read: falling edges while held must not advance
        rd_data = 8'h3C; s0 = n_rdn;
        cs_begin(); send_byte(8'h05);
        recv_byte(b); check_eq("R5 hold byte0", b, 8'h3C);
        hold_n = 1'b0; wait_n(3);
        check_eq("R11 oe held", sio_oe, 0);
        for (int i = 0; i < 3; i++) begin logic [3:0] q; cyc(4'hF, q); end
        check_eq("R11 no advance", n_rdn - s0, 1);
        hold_n = 1'b1; wait_n(2);
        recv_byte(b); check_eq("R11 byte after hold", b, 8'h3C);
        cs_end();

        // R11 hold splitting an opcode
        s0 = n_wren;
        cs_begin();
        for (int i = 0; i < 4; i++) begin logic [3:0] q; cyc(4'h0, q); end
        hold_n = 1'b0; wait_n(2);
        for (int i = 0; i < 4; i++) begin logic [3:0] q; cyc(4'h1, q); end
        hold_n = 1'b1; wait_n(2);
        begin logic [3:0] q; cyc(4'h0, q); cyc(4'h1, q); cyc(4'h1, q); cyc(4'h0, q); end
        cs_end();
        check_eq("R11 opcode frozen", op_code, 8'h06);
        check_eq("R11 wren after hold", n_wren - s0, 1);

        // R11 hold ignored when pins disabled
        cfg_pin_dis = 1'b1; hold_n = 1'b0; s0 = n_wrdi;
        one_cmd(8'h04);
        check_eq("R11 hold ignored cfg", n_wrdi - s0, 1);
        hold_n = 1'b1; cfg_pin_dis = 1'b0;

        // R4 R5 read with address, single mode
        rd_data = 8'h96; s0 = n_av; s1 = n_rdn;
        cs_begin(); send_byte(8'h03); send_byte(8'h12); send_byte(8'h34); send_byte(8'h56);
        check_eq("R4 addr_valid", n_av - s0, 1);
        check_eq("R4 addr", addr, 24'h123456);
        check_eq("R5 no rd_next before data", n_rdn - s1, 0);
        recv_byte(b); check_eq("R5 read data", b, 8'h96);
        cs_end();

        // R3 R6 R10 R11 R12 quad fast read with dummy byte
        one_cmd(8'h38); bq = 1'b1;
        hold_n = 1'b0; wp_n = 1'b0; wait_n(1);
        check_eq("R12 wp in quad", wp_active, 0);
        rd_data = 8'h5A; s0 = n_rdn;
        cs_begin(); send_byte(8'h0B); send_byte(8'hAB); send_byte(8'hCD); send_byte(8'hEF);
        send_byte(8'h00);
        check_eq("R6 no rd_next in dummy", n_rdn - s0, 0);
        recv_byte(b); check_eq("R6 fast read nibbles", b, 8'h5A);
        check_eq("R10 oe quad", sio_oe, 4'b1111);
        check_eq("R4 quad addr", addr, 24'hABCDEF);
        cs_end();
        hold_n = 1'b1; wp_n = 1'b1;

        // R7 page cap in quad mode
        s0 = n_wr; s1 = n_prog;
        cs_begin(); send_byte(8'h02); send_byte(8'h00); send_byte(8'hAB); send_byte(8'h00);
        for (int i = 0; i < 258; i++) send_byte(8'(i));
        cs_end();
        check_eq("R7 page cap", n_wr - s0, 256);
        check_eq("R7 last kept byte", last_wr, 8'hFF);
        check_eq("R7 prog_go quad", n_prog - s1, 1);
        one_cmd(8'hFF); bq = 1'b0;
        check_eq("R3 back to single", quad_mode, 0);

        // R7 small program, single mode
        s0 = n_wr; s1 = n_prog;
        cs_begin(); send_byte(8'h02); send_byte(8'h00); send_byte(8'h01); send_byte(8'h00);
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
        cs_end();
        check_eq("R7 write count", n_wr - s0, 3);
        check_eq("R7 write data", last_wr, 8'h33);
        check_eq("R7 prog_go", n_prog - s1, 1);

        // R9 abort mid address
        s0 = n_av; s1 = n_prog;
        cs_begin(); send_byte(8'h02); send_byte(8'h00); send_byte(8'h02); cs_end();
        check_eq("R9 no addr_valid", n_av - s0, 0);
        check_eq("R9 no prog_go", n_prog - s1, 0);

        // R8 erase, full and aborted
        s0 = n_erase;
        cs_begin(); send_byte(8'h20); send_byte(8'h00); send_byte(8'hF0); send_byte(8'h00); cs_end();
        check_eq("R8 erase_go", n_erase - s0, 1);
        check_eq("R8 erase addr", addr, 24'h00F000);
        s0 = n_erase;
        cs_begin(); send_byte(8'h20); send_byte(8'h01); cs_end();
        check_eq("R9 erase aborted", n_erase - s0, 0);

        // R9 abort mid opcode, then a clean command
        s0 = n_op; s1 = n_wrdi;
        cs_begin();
        for (int i = 0; i < 4; i++) begin logic [3:0] q; cyc(4'h1, q); end
        cs_end();
        check_eq("R9 partial opcode dropped", n_op - s0, 0);
        one_cmd(8'h04);
        check_eq("R9 clean after abort", op_code, 8'h04);
        check_eq("R9 wrdi after abort", n_wrdi - s1, 1);

        // R12 write-protect reporting
        wp_n = 1'b0; wait_n(1);
        check_eq("R12 wp single", wp_active, 1);
        cfg_pin_dis = 1'b1; wait_n(1);
        check_eq("R12 wp disabled", wp_active, 0);
        cfg_pin_dis = 1'b0; wp_n = 1'b1; wait_n(1);
        check_eq("R12 wp released", wp_active, 0);

        // R13 clock idling high
        idle_hi = 1'b1; wait_n(3);
        s0 = n_wren;
        one_cmd(8'h06);
        check_eq("R13 mode3 wren", n_wren - s0, 1);
        rd_data = 8'hC3;
        cs_begin(); send_byte(8'h35); recv_byte(b); cs_end();
        check_eq("R13 mode3 read", b, 8'hC3);
        idle_hi = 1'b0; wait_n(3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule